// File: doc/BRIEF.md
# SRAM Bring-Up Pattern Sequencer

This block exercises an external byte-wide asynchronous static RAM from a synchronous clock domain. The RAM is reached through three active-low strobes (chip select, read enable and write strobe), a 13-bit address and an 8-bit data path. On chip the data path is split into an output byte, a drive-enable and an input byte; the pad ring joins them into one bidirectional bus.

After a one-cycle start pulse the sequencer runs a fixed script of bus operations. It first issues a burst of warm-up writes. It then writes a set of progressive address and data patterns and reads them back, comparing each byte. It ends with two negative checks, which show that a write cycle does nothing when chip select stays off and nothing when the write strobe never fires. Every bus step lasts a parameterised number of clocks.

When the script ends the block raises `done` and reports pass or fail. On a failure it also reports the address, the expected byte and the byte that was read at the first miscompare. A new start pulse clears the result and runs the script again.

Top module: `sram_script_tester`

## Requirements
- R1: After reset all three strobes are high (inactive), the data drive-enable is low, the address is 0, and `done` and `pass` are 0.
- R2: The script opens with WARM_CNT (default 128) write cycles, each writing 0x01 to address 0x0000. No other bus operation comes before them.
- R3: A write cycle takes five steps of STEP_CYC clocks each. Step 0: address only. Step 1: chip select low. Step 2: data driven. Step 3: write strobe low for exactly one step. Step 4: all strobes high while the data is still driven. The address stays stable while chip select is low.
- R4: A read cycle takes four steps. Step 0: address only. Step 1: chip select low. Step 2: chip select and read enable low, with the input byte sampled on the clock edge where the in-step counter equals SAMPLE_CYC. Step 3: all strobes high. Read enable is low for exactly one step.
- R5: The write pass uses fourteen addresses in this order: 0x0001, 0x0003, 0x0007, and so on, each adding one more low-order one, up to 0x1FFF, then 0x0000. The bytes written are, in order: 01, 03, 07, 0F, 1F, 3F, 7F, FF, FE, FD, FB, F7, EF, DF.
- R6: The read pass visits the same fourteen addresses in the same order and compares each byte with the R5 value. It is followed by one write of 0xFE to 0x0001.
- R7: Chip-select check: write 0x01 to 0x0001. Then run a write cycle carrying 0x03 in which the write strobe pulses but chip select stays high. Then read 0x0001, expecting 0x01.
- R8: Write-strobe check: write 0x03 to 0x0000. Then run a cycle with chip select low and 0x01 driven in which the write strobe never goes low. Then read 0x0000, expecting 0x03.
- R9: The data drive-enable is never high while read enable is low. Read enable and the write strobe are never low together. The write strobe is low only while data is driven.
- R10: At the end of the script `done` rises and holds until the next start. `pass` is 1 only when every compare matched, and it is never 1 without `done`. `done` is cleared on the edge that accepts a start.
- R11: On the first miscompare the block latches the address, the expected byte and the actual byte. Later miscompares do not overwrite them, and the script still runs to its end.
- R12: A start pulse that arrives while the script is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that launches the script |
| ram_addr | output | ADDR_W (13) | RAM address |
| ram_ce_n | output | 1 | Chip select, active low |
| ram_oe_n | output | 1 | Read enable, active low |
| ram_we_n | output | 1 | Write strobe, active low |
| ram_dq_out | output | DATA_W (8) | Byte driven toward the RAM |
| ram_dq_drive | output | 1 | High while the byte is driven onto the bus |
| ram_dq_in | input | DATA_W (8) | Byte read from the bus |
| done | output | 1 | Script finished |
| pass | output | 1 | Script finished with no miscompare |
| fail_addr | output | ADDR_W (13) | Address of the first miscompare |
| fail_exp | output | DATA_W (8) | Expected byte at the first miscompare |
| fail_act | output | DATA_W (8) | Byte read at the first miscompare |

## Verification
The bench RAM model returns valid data only in a short window around the intended sample clock and returns the inverted byte at all other times. A sequencer that sampled early or late would therefore see a wrong byte and report a false failure. In a second run the model corrupts two read addresses, so a design that let a later miscompare overwrite the first would report 0x07FF instead of 0x003F. The scoreboard holds the exact order of bus operations, so a sequencer that restarts on a stray start pulse, drops the chip-select test cycle or lets the write-enable test cycle pulse the strobe shows up as a mismatch or an underflow. At the end the model's contents must show 0x01 at 0x0001 and 0x03 at 0x0000, which a block that let either negative cycle through would overwrite.

// File: rtl/sst_pkg.sv
// Shared types for the SRAM pattern sequencer.
// Assumes: one bus operation at a time; step counts are fixed by the cycle shape.
package sst_pkg;
    typedef enum logic [1:0] {
        OP_WR      = 2'd0,
        OP_WR_NOCE = 2'd1,
        OP_WR_NOWE = 2'd2,
        OP_RD      = 2'd3
    } sst_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } sst_state_e;

    localparam int WR_STEPS = 5;
    localparam int RD_STEPS = 4;
endpackage

// File: rtl/sst_step_timer.sv
// Step timer: counts clocks inside one bus step and flags the step end and the
// read sample point.
// Assumes: SAMPLE_CYC < STEP_CYC; clr has priority over run.
module sst_step_timer #(
    parameter int STEP_CYC   = 25,
    parameter int SAMPLE_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic step_end,
    output logic sample_hit
);
    localparam int CNT_W = $clog2(STEP_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_CYC - 1);
    localparam logic [CNT_W-1:0] CNT_SMP  = CNT_W'(SAMPLE_CYC);

    logic [CNT_W-1:0] cnt;

    // Clock counter inside the current step, wrapping at the step length.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= (cnt == CNT_LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign step_end   = run && (cnt == CNT_LAST);
    assign sample_hit = run && (cnt == CNT_SMP);
endmodule

// File: rtl/sst_script.sv
// Script decoder: maps a script index to the operation, address and byte.
// Order: warm-up writes, walking write pass, read-back pass, then the fixed
// tail of chip-select and write-strobe checks.
// Assumes: ADDR_W + 1 - DATA_W <= DATA_W, so the walking-zero bytes fit.
module sst_script
    import sst_pkg::*;
#(
    parameter int ADDR_W   = 13,
    parameter int DATA_W   = 8,
    parameter int WARM_CNT = 128,
    parameter int IDX_W    = 8
) (
    input  logic [IDX_W-1:0]  idx,
    output sst_op_e           op,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    localparam int WALK_N = ADDR_W + 1;

    // k-th walking address: k+1 low-order ones, the last entry wraps to zero.
    function automatic logic [ADDR_W-1:0] walk_addr(input int k);
        logic [63:0] v;
        v = (k < ADDR_W) ? ((64'd1 << (k + 1)) - 64'd1) : 64'd0;
        return v[ADDR_W-1:0];
    endfunction

    // k-th pattern byte: rising ones, then a single travelling zero.
    function automatic logic [DATA_W-1:0] walk_data(input int k);
        logic [63:0] v;
        if (k < DATA_W) v = (64'd1 << (k + 1)) - 64'd1;
        else            v = ~(64'd1 << (k - DATA_W));
        return v[DATA_W-1:0];
    endfunction

    int j;

    // Decode the current script entry.
    always_comb begin
        j    = int'(idx) - WARM_CNT;
        op   = OP_WR;
        addr = '0;
        data = DATA_W'(1);
        if (j >= 0) begin
            if (j < WALK_N) begin
                addr = walk_addr(j);
                data = walk_data(j);
            end else if (j < 2 * WALK_N) begin
                op   = OP_RD;
                addr = walk_addr(j - WALK_N);
                data = walk_data(j - WALK_N);
            end else begin
                case (j - 2 * WALK_N)
                    0:       begin op = OP_WR;      addr = ADDR_W'(1); data = ~DATA_W'(1); end
                    1:       begin op = OP_WR;      addr = ADDR_W'(1); data = DATA_W'(1);  end
                    2:       begin op = OP_WR_NOCE; addr = ADDR_W'(1); data = DATA_W'(3);  end
                    3:       begin op = OP_RD;      addr = ADDR_W'(1); data = DATA_W'(1);  end
                    4:       begin op = OP_WR;      addr = '0;         data = DATA_W'(3);  end
                    5:       begin op = OP_WR_NOWE; addr = '0;         data = DATA_W'(1);  end
                    default: begin op = OP_RD;      addr = '0;         data = DATA_W'(3);  end
                endcase
            end
        end
    end
endmodule

// File: rtl/sram_script_tester.sv
// SRAM pattern sequencer top: walks the script, shapes each operation into
// timed strobe steps, compares read bytes and keeps the first failure.
// Assumes: the pad ring merges ram_dq_out/ram_dq_drive/ram_dq_in into one
// bus; ram_dq_in is stable at the sample edge.
module sram_script_tester
    import sst_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int DATA_W     = 8,
    parameter int WARM_CNT   = 128,
    parameter int STEP_CYC   = 25,
    parameter int SAMPLE_CYC = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_ce_n,
    output logic              ram_oe_n,
    output logic              ram_we_n,
    output logic [DATA_W-1:0] ram_dq_out,
    output logic              ram_dq_drive,
    input  logic [DATA_W-1:0] ram_dq_in,
    output logic              done,
    output logic              pass,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [DATA_W-1:0] fail_exp,
    output logic [DATA_W-1:0] fail_act
);
    localparam int WALK_N = ADDR_W + 1;
    localparam int ITEM_N = WARM_CNT + 2 * WALK_N + 7;
    localparam int IDX_W  = $clog2(ITEM_N);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ITEM_N - 1);

    sst_state_e        state;
    logic [IDX_W-1:0]  idx;
    logic [2:0]        step;
    logic              fail_seen;
    logic              run, launch, step_end, sample_hit, last_step, miscmp;
    sst_op_e           cur_op;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_data;

    assign run    = (state == ST_RUN);
    assign launch = start && !run;

    sst_step_timer #(.STEP_CYC(STEP_CYC), .SAMPLE_CYC(SAMPLE_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(launch), .run(run),
        .step_end(step_end), .sample_hit(sample_hit)
    );

    sst_script #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WARM_CNT(WARM_CNT), .IDX_W(IDX_W)) u_script (
        .idx(idx), .op(cur_op), .addr(cur_addr), .data(cur_data)
    );

    assign last_step = (cur_op == OP_RD) ? (step == 3'(RD_STEPS - 1))
                                         : (step == 3'(WR_STEPS - 1));
    assign miscmp    = run && sample_hit && (cur_op == OP_RD) && (step == 3'd2)
                       && (ram_dq_in != cur_data);

    // Script walker, result flags and first-failure capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            idx       <= '0;
            step      <= '0;
            done      <= 1'b0;
            pass      <= 1'b0;
            fail_seen <= 1'b0;
            fail_addr <= '0;
            fail_exp  <= '0;
            fail_act  <= '0;
        end else if (launch) begin
            state     <= ST_RUN;
            idx       <= '0;
            step      <= '0;
            done      <= 1'b0;
            pass      <= 1'b0;
            fail_seen <= 1'b0;
            fail_addr <= '0;
            fail_exp  <= '0;
            fail_act  <= '0;
        end else if (run) begin
            if (miscmp && !fail_seen) begin
                fail_seen <= 1'b1;
                fail_addr <= cur_addr;
                fail_exp  <= cur_data;
                fail_act  <= ram_dq_in;
            end
            if (step_end) begin
                if (!last_step) begin
                    step <= step + 3'd1;
                end else begin
                    step <= '0;
                    if (idx == IDX_LAST) begin
                        state <= ST_FIN;
                        done  <= 1'b1;
                        pass  <= !fail_seen;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
            end
        end
    end

    // Strobe and data-path shaping from the operation and its step.
    always_comb begin
        ram_addr     = '0;
        ram_ce_n     = 1'b1;
        ram_oe_n     = 1'b1;
        ram_we_n     = 1'b1;
        ram_dq_drive = 1'b0;
        if (run) begin
            ram_addr = cur_addr;
            if (cur_op == OP_RD) begin
                ram_ce_n = !(step == 3'd1 || step == 3'd2);
                ram_oe_n = !(step == 3'd2);
            end else begin
                ram_ce_n     = !((cur_op != OP_WR_NOCE) && step >= 3'd1 && step <= 3'd3);
                ram_dq_drive = (step >= 3'd2);
                ram_we_n     = !((cur_op != OP_WR_NOWE) && step == 3'd3);
            end
        end
        ram_dq_out = ram_dq_drive ? cur_data : '0;
    end
endmodule

// File: rtl/sram_script_tester_chk.sv
// Protocol checker for the SRAM pattern sequencer, bound to the top.
// Assumes: observes top ports only.
module sram_script_tester_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              ram_ce_n,
    input logic              ram_oe_n,
    input logic              ram_we_n,
    input logic              ram_dq_drive,
    input logic              done,
    input logic              pass,
    input logic [ADDR_W-1:0] fail_addr
);
    p_rest_after_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ram_ce_n && ram_oe_n && ram_we_n && !ram_dq_drive));

    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_ce_n && $past(!ram_ce_n)) |-> $stable(ram_addr));

    p_we_with_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> ram_dq_drive);

    p_no_contention_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ram_dq_drive |-> ram_oe_n);

    p_oe_we_apart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_oe_n |-> ram_we_n);

    p_pass_needs_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> done);

    p_done_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    p_fail_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> $stable(fail_addr));
endmodule

bind sram_script_tester sram_script_tester_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .ram_addr(ram_addr),
    .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
    .ram_dq_drive(ram_dq_drive), .done(done), .pass(pass), .fail_addr(fail_addr)
);

// File: tb/test_sram_script_tester.sv
`timescale 1ns/1ps
// Scoreboard bench: a driver task queues the expected bus operations, a
// monitor pops them as strobe pulses complete; a behavioural RAM answers reads.
module test_sram_script_tester;
    localparam int STEP = 25;
    localparam int SMP  = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [12:0] ram_addr;
    logic        ram_ce_n, ram_oe_n, ram_we_n, ram_dq_drive;
    logic [7:0]  ram_dq_out;
    logic [7:0]  ram_dq_in = 8'h00;
    logic        done, pass;
    logic [12:0] fail_addr;
    logic [7:0]  fail_exp, fail_act;

    always #10 clk = ~clk;

    sram_script_tester #(.STEP_CYC(STEP), .SAMPLE_CYC(SMP)) i_sram_script_tester (
        .clk(clk), .rst_n(rst_n), .start(start), .ram_addr(ram_addr),
        .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
        .ram_dq_out(ram_dq_out), .ram_dq_drive(ram_dq_drive), .ram_dq_in(ram_dq_in),
        .done(done), .pass(pass), .fail_addr(fail_addr),
        .fail_exp(fail_exp), .fail_act(fail_act)
    );

    typedef struct {
        int    kind;   // 0 write, 1 write with chip select held off, 2 read
        int    addr;
        int    data;
        string tag;
    } item_t;

    item_t      exp_q[$];
    logic [7:0] model[int];
    int  total = 0;
    int  bad   = 0;
    bit  inject = 1'b0;
    int  contention = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic push(input int kind, input int addr, input int data, input string tag);
        item_t it;
        it.kind = kind; it.addr = addr; it.data = data; it.tag = tag;
        exp_q.push_back(it);
    endtask

    // Driver: the whole expected operation stream of one script run.
    task automatic push_script();
        int adr[14] = '{'h0001, 'h0003, 'h0007, 'h000F, 'h001F, 'h003F, 'h007F,
                        'h00FF, 'h01FF, 'h03FF, 'h07FF, 'h0FFF, 'h1FFF, 'h0000};
        int dat[14] = '{'h01, 'h03, 'h07, 'h0F, 'h1F, 'h3F, 'h7F,
                        'hFF, 'hFE, 'hFD, 'hFB, 'hF7, 'hEF, 'hDF};
        for (int i = 0; i < 128; i++) push(0, 0, 'h01, "R2 warm-up write");
        for (int i = 0; i < 14; i++)  push(0, adr[i], dat[i], "R5 pattern write");
        for (int i = 0; i < 14; i++)  push(2, adr[i], dat[i], "R6 read-back");
        push(0, 1, 'hFE, "R6 trailing write");
        push(0, 1, 'h01, "R7 setup write");
        push(1, 1, 'h03, "R7 blocked write");
        push(2, 1, 'h01, "R7 read");
        push(0, 0, 'h03, "R8 setup write");
        push(2, 0, 'h03, "R8 read");
    endtask

    // RAM model, read-window shaping and bus monitor, all away from the active edge.
    bit p_we = 1'b1, p_oe = 1'b1, p_drive = 1'b0;
    int olc = 0, we_len = 0, oe_len = 0;
    bit we_ce = 1'b1, we_early = 1'b0;
    int we_addr = 0, we_data = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!ram_ce_n && !ram_we_n && ram_dq_drive) model[int'(ram_addr)] = ram_dq_out;
            olc = ram_oe_n ? 0 : olc + 1;
            if (!ram_ce_n && !ram_oe_n && ram_we_n) begin
                logic [7:0] v;
                v = model.exists(int'(ram_addr)) ? model[int'(ram_addr)] : 8'h00;
                if (inject && ram_addr == 13'h003F) v = v ^ 8'h10;
                if (inject && ram_addr == 13'h07FF) v = v ^ 8'h01;
                ram_dq_in = (olc >= SMP - 3 && olc <= SMP + 3) ? v : ~v;
            end else begin
                ram_dq_in = 8'hA5;
            end
            if (ram_dq_drive && !ram_oe_n) contention++;

            if (p_we && !ram_we_n) begin
                we_len = 1; we_ce = ram_ce_n; we_addr = int'(ram_addr);
                we_data = int'(ram_dq_out); we_early = p_drive;
            end else if (!ram_we_n) begin
                we_len++;
            end
            if (!p_we && ram_we_n) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R12 unexpected write pulse", we_addr, -1);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    chk(it.kind != 2 && we_addr == it.addr && we_data == it.data,
                        it.tag, (we_addr << 8) | we_data, (it.addr << 8) | it.data);
                    chk(we_ce == (it.kind == 1), it.tag, int'(we_ce), int'(it.kind == 1));
                    chk(we_len == STEP && we_early && ram_dq_drive && ram_ce_n,
                        "R3 write shape", we_len, STEP);
                end
            end

            if (p_oe && !ram_oe_n) oe_len = 1;
            else if (!ram_oe_n) oe_len++;
            if (!p_oe && ram_oe_n) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R12 unexpected read pulse", int'(ram_addr), -1);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    chk(it.kind == 2 && int'(ram_addr) == it.addr, it.tag, int'(ram_addr), it.addr);
                    chk(oe_len == STEP, "R4 read enable length", oe_len, STEP);
                end
            end
        end
        p_we = ram_we_n; p_oe = ram_oe_n; p_drive = ram_dq_drive;
    end

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done();
        int c;
        c = 0;
        while (!done && c < 40000) begin @(negedge clk); c++; end
        chk(done, "R10 done within bound", int'(done), 1);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Global watchdog.
    initial begin
        #4_000_000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(ram_ce_n && ram_oe_n && ram_we_n && !ram_dq_drive && ram_addr == 0 && !done && !pass,
            "R1 reset state", {ram_ce_n, ram_oe_n, ram_we_n, ram_dq_drive, done, pass}, 6'b111000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Run 1: clean memory, with a stray start pulse during the warm-up.
        push_script();
        pulse_start();
        chk(!done, "R10 done low while running", int'(done), 0);
        repeat (3000) @(negedge clk);
        pulse_start();
        wait_done();
        chk(pass, "R10 pass on clean run", int'(pass), 1);
        chk(exp_q.size() == 0, "R12 stream complete", exp_q.size(), 0);
        chk(model[1] == 8'h01, "R7 memory at 0x0001", int'(model[1]), 'h01);
        chk(model[0] == 8'h03, "R8 memory at 0x0000", int'(model[0]), 'h03);
        chk(model['h1FFF] == 8'hEF, "R5 memory at 0x1FFF", int'(model['h1FFF]), 'hEF);
        chk(fail_addr == 0, "R11 no failure recorded", int'(fail_addr), 0);
        chk(contention == 0, "R9 bus contention", contention, 0);

        // Run 2: two corrupted read addresses; the first must be kept.
        inject = 1'b1;
        push_script();
        pulse_start();
        chk(!done && !pass, "R10 done cleared by start", int'(done), 0);
        wait_done();
        chk(!pass, "R11 fail reported", int'(pass), 0);
        chk(fail_addr == 13'h003F, "R11 first fail address", int'(fail_addr), 'h003F);
        chk(fail_exp == 8'h3F && fail_act == 8'h2F, "R11 first fail bytes",
            (int'(fail_exp) << 8) | int'(fail_act), 'h3F2F);
        chk(exp_q.size() == 0, "R11 script ran to end", exp_q.size(), 0);
        chk(contention == 0, "R9 bus contention", contention, 0);
        finish_run();
    end
endmodule